// File: doc/BRIEF.md
# Radio Link Mode and Channel Sequencer

This block drives a half-duplex narrow-band radio module from the host side. It owns the module supply switch and the two active-low select lines: receive select (`rx_sel_n_o`) and transmit select (`tx_sel_n_o`). It hands channel words to an external serial loader through a request/done handshake, and it gates the data line into the module. After reset it starts with both selects released and the supply off. It switches the supply on, waits for the supply to settle, and then parks the module in receive mode until the host asks for a channel.

Every retune happens with receive selected. If a retune is requested while transmitting, the sequencer first drops to receive and then starts the loader. Each event gets its own settling wait: a long window for the first lock after power-up, a shorter one for later retunes, and a short one for a plain mode switch on an unchanged channel. The lock-detect input (high = locked) is looked at only on the last cycle of a settling window, because it may chatter before the loop has truly locked. A failed check raises a lock-error flag and reprograms the channel a bounded number of times. When transmit starts, a preamble is sent on the data line before the payload path is opened.

All waits are given in milliseconds and turned into cycle counts from a clock-frequency parameter, so a bench can run at a scaled clock.

Top module: `radio_link_sequencer`

## Requirements
- R1: While reset is applied and for the first cycle after the internal reset releases, `pwr_en_o` is 0 and both selects are 1. `pwr_en_o` then rises with both selects still 1, and they stay 1 for PWRUP_MS worth of cycles, after which receive select goes low.
- R2: On the first successful lock since reset, `data_ready_o` rises exactly FIRST_MS worth of cycles after the clock edge that samples `ld_done_i` high.
- R3: On every later channel programming, `data_ready_o` rises exactly RETUNE_MS worth of cycles after the edge that samples `ld_done_i` high.
- R4: `ld_req_o` is high only while receive select is 0 and transmit select is 1. A channel request made during transmit passes through receive mode before `ld_req_o` rises.
- R5: Lock-detect is used only on the last cycle of a settling window. Its value on earlier cycles of the window has no effect.
- R6: If lock-detect is 0 at the check, `lock_err_o` goes to 1 and `data_ready_o` stays 0. The loader is started again, for at most MAX_RETRY repeats (MAX_RETRY+1 requests in all). After that the block waits in receive mode, not ready, with the flag held. A later successful lock clears the flag.
- R7: A receive request while transmitting, with no retune, gives `data_ready_o` exactly SWITCH_MS worth of cycles after receive select falls.
- R8: A transmit request while receiving gives `data_ready_o` exactly SWITCH_MS + PREAMBLE_MS worth of cycles after transmit select falls.
- R9: During the preamble phase, `di_o` carries a fixed pattern, each bit lasting BIT_DIV cycles. With PATTERN=0 the pattern is 1,0,1,0,… and with PATTERN=1 it is 1,1,0,0,…; both start with 1. In the ready transmit state `di_o` follows `tx_data_i`; elsewhere it is 0.
- R10: The selects are active low and are never both 0. Every change of mode leaves both selects at 1 for one cycle.
- R11: The channel word is captured on an accepted channel request and driven on `ld_chan_o`. Requests are ignored during power-up, loading and settling; transmit and receive requests are also ignored while the block waits for a channel. A request for the mode already held is ignored. A channel request wins over a simultaneous mode request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chan_req_i | input | 1 | One-cycle request to retune |
| chan_sel_i | input | CHAN_W | Channel word captured with `chan_req_i` |
| tx_req_i | input | 1 | One-cycle request for transmit mode |
| rx_req_i | input | 1 | One-cycle request for receive mode |
| ld_done_i | input | 1 | Serial loader has finished programming |
| lock_i | input | 1 | Lock-detect from the module, 1 = locked |
| tx_data_i | input | 1 | Payload bit to send |
| pwr_en_o | output | 1 | Module supply switch, 1 = on |
| rx_sel_n_o | output | 1 | Receive select, active low |
| tx_sel_n_o | output | 1 | Transmit select, active low |
| ld_req_o | output | 1 | Loader request, held until `ld_done_i` |
| ld_chan_o | output | CHAN_W | Channel word for the loader |
| data_ready_o | output | 1 | Data may be exchanged in the current mode |
| lock_err_o | output | 1 | Last lock check failed |
| di_o | output | 1 | Data line into the module |

## Verification
The sequencer is driven through a first lock with lock-detect chattering early in the window. It is then driven through a retune requested from transmit, and through a retune attempt where lock-detect is high for most of the window but low at its end. These cases separate the long first window from the short later one, and a check at the window's end from a check anywhere in it. Mode switches go both ways, one of them cut short in the middle of the preamble, which tells the plain switch delay apart from the delay with preamble. Requests made in busy or waiting states, and a channel request together with a transmit request, show which requests are dropped and which wins.

// File: rtl/rls_pkg.sv
package rls_pkg;
  typedef enum logic [3:0] {
    ST_OFF, ST_PWR, ST_IDLE, ST_LOAD, ST_SETTLE,
    ST_RX, ST_RXSW, ST_GAP, ST_TXSW, ST_PRE, ST_TX
  } seq_state_e;

  typedef enum logic [1:0] {GO_RX, GO_TX, GO_LOAD} gap_dest_e;
endpackage

// File: rtl/rls_timer.sv
module rls_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/rls_preamble.sv
module rls_preamble #(
  parameter int BIT_DIV = 1,
  parameter int PATTERN = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic bit_o
);
  logic       step;
  logic [1:0] idx_q, idx_d;

  generate
    if (BIT_DIV > 1) begin : g_div
      localparam int DW = $clog2(BIT_DIV);
      localparam logic [DW-1:0] LAST = DW'(BIT_DIV - 1);
      logic [DW-1:0] div_q, div_d;

      always_comb begin
        if (!en || div_q == LAST) div_d = '0;
        else                      div_d = div_q + DW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
      end

      assign step = en && (div_q == LAST);
    end else begin : g_nodiv
      assign step = en;
    end
  endgenerate

  always_comb begin
    if (!en)       idx_d = 2'd0;
    else if (step) idx_d = idx_q + 2'd1;
    else           idx_d = idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= 2'd0;
    else        idx_q <= idx_d;
  end

  assign bit_o = ~((PATTERN == 0) ? idx_q[0] : idx_q[1]);
endmodule

// File: rtl/rls_ctrl.sv
module rls_ctrl
  import rls_pkg::*;
#(
  parameter int TW        = 8,
  parameter int CHAN_W    = 5,
  parameter int MAX_RETRY = 2,
  parameter logic [TW-1:0] LV_PWR    = '0,
  parameter logic [TW-1:0] LV_FIRST  = '0,
  parameter logic [TW-1:0] LV_RETUNE = '0,
  parameter logic [TW-1:0] LV_SWITCH = '0,
  parameter logic [TW-1:0] LV_PRE    = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_chan,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic              req_tx,
  input  logic              req_rx,
  input  logic              ld_done,
  input  logic              lock,
  input  logic              tmr_done,
  output logic              tmr_load,
  output logic [TW-1:0]     tmr_val,
  output logic              pwr_en,
  output logic              rx_sel_n,
  output logic              tx_sel_n,
  output logic              ld_req,
  output logic [CHAN_W-1:0] ld_chan,
  output logic              data_ready,
  output logic              lock_err,
  output logic              pre_en,
  output logic              tx_pass
);
  localparam int RW = $clog2(MAX_RETRY + 2);
  localparam logic [RW-1:0] TRY_LIM = RW'(MAX_RETRY);

  seq_state_e        st_q, st_d;
  gap_dest_e         dest_q, dest_d;
  logic [CHAN_W-1:0] chan_q, chan_d;
  logic [RW-1:0]     try_q, try_d;
  logic              first_q, first_d;
  logic              err_q, err_d;

  always_comb begin
    st_d     = st_q;
    dest_d   = dest_q;
    chan_d   = chan_q;
    try_d    = try_q;
    first_d  = first_q;
    err_d    = err_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st_q)
      ST_OFF: begin
        st_d     = ST_PWR;
        tmr_load = 1'b1;
        tmr_val  = LV_PWR;
      end
      ST_PWR: if (tmr_done) st_d = ST_IDLE;
      ST_IDLE: if (req_chan) begin
        chan_d = chan_i;
        try_d  = '0;
        st_d   = ST_LOAD;
      end
      ST_LOAD: if (ld_done) begin
        st_d     = ST_SETTLE;
        tmr_load = 1'b1;
        tmr_val  = first_q ? LV_FIRST : LV_RETUNE;
      end
      ST_SETTLE: if (tmr_done) begin
        if (lock) begin
          st_d    = ST_RX;
          first_d = 1'b0;
          err_d   = 1'b0;
          try_d   = '0;
        end else begin
          err_d = 1'b1;
          if (try_q < TRY_LIM) begin
            try_d = try_q + RW'(1);
            st_d  = ST_LOAD;
          end else begin
            try_d = '0;
            st_d  = ST_IDLE;
          end
        end
      end
      ST_RX, ST_RXSW: begin
        if (req_chan) begin
          chan_d = chan_i;
          try_d  = '0;
          st_d   = ST_LOAD;
        end else if (req_tx) begin
          dest_d = GO_TX;
          st_d   = ST_GAP;
        end else if (st_q == ST_RXSW && tmr_done) begin
          st_d = ST_RX;
        end
      end
      ST_TXSW, ST_PRE, ST_TX: begin
        if (req_chan) begin
          chan_d = chan_i;
          try_d  = '0;
          dest_d = GO_LOAD;
          st_d   = ST_GAP;
        end else if (req_rx) begin
          dest_d = GO_RX;
          st_d   = ST_GAP;
        end else if (st_q == ST_TXSW && tmr_done) begin
          st_d     = ST_PRE;
          tmr_load = 1'b1;
          tmr_val  = LV_PRE;
        end else if (st_q == ST_PRE && tmr_done) begin
          st_d = ST_TX;
        end
      end
      ST_GAP: begin
        case (dest_q)
          GO_TX: begin
            st_d     = ST_TXSW;
            tmr_load = 1'b1;
            tmr_val  = LV_SWITCH;
          end
          GO_RX: begin
            st_d     = ST_RXSW;
            tmr_load = 1'b1;
            tmr_val  = LV_SWITCH;
          end
          default: st_d = ST_LOAD;
        endcase
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OFF;
      dest_q  <= GO_RX;
      chan_q  <= '0;
      try_q   <= '0;
      first_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      dest_q  <= dest_d;
      chan_q  <= chan_d;
      try_q   <= try_d;
      first_q <= first_d;
      err_q   <= err_d;
    end
  end

  assign pwr_en     = (st_q != ST_OFF);
  assign rx_sel_n   = !(st_q inside {ST_IDLE, ST_LOAD, ST_SETTLE, ST_RX, ST_RXSW});
  assign tx_sel_n   = !(st_q inside {ST_TXSW, ST_PRE, ST_TX});
  assign ld_req     = (st_q == ST_LOAD);
  assign ld_chan    = chan_q;
  assign data_ready = (st_q == ST_RX) || (st_q == ST_TX);
  assign lock_err   = err_q;
  assign pre_en     = (st_q == ST_PRE);
  assign tx_pass    = (st_q == ST_TX);
endmodule

// File: rtl/radio_link_sequencer.sv
module radio_link_sequencer #(
  parameter int CLK_HZ      = 20_000_000,
  parameter int PWRUP_MS    = 5,
  parameter int FIRST_MS    = 40,
  parameter int RETUNE_MS   = 20,
  parameter int SWITCH_MS   = 5,
  parameter int PREAMBLE_MS = 15,
  parameter int MAX_RETRY   = 2,
  parameter int CHAN_W      = 5,
  parameter int BIT_DIV     = 2083,
  parameter int PATTERN     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_req_i,
  input  logic [CHAN_W-1:0] chan_sel_i,
  input  logic              tx_req_i,
  input  logic              rx_req_i,
  input  logic              ld_done_i,
  input  logic              lock_i,
  input  logic              tx_data_i,
  output logic              pwr_en_o,
  output logic              rx_sel_n_o,
  output logic              tx_sel_n_o,
  output logic              ld_req_o,
  output logic [CHAN_W-1:0] ld_chan_o,
  output logic              data_ready_o,
  output logic              lock_err_o,
  output logic              di_o
);
  localparam int CYC_MS   = CLK_HZ / 1000;
  localparam int C_PWR    = PWRUP_MS * CYC_MS;
  localparam int C_FIRST  = FIRST_MS * CYC_MS;
  localparam int C_RETUNE = RETUNE_MS * CYC_MS;
  localparam int C_SWITCH = SWITCH_MS * CYC_MS;
  localparam int C_PRE    = PREAMBLE_MS * CYC_MS;
  localparam int C_M1     = (C_PWR > C_FIRST) ? C_PWR : C_FIRST;
  localparam int C_M2     = (C_RETUNE > C_SWITCH) ? C_RETUNE : C_SWITCH;
  localparam int C_M3     = (C_M1 > C_M2) ? C_M1 : C_M2;
  localparam int C_MAX    = (C_M3 > C_PRE) ? C_M3 : C_PRE;
  localparam int TW       = $clog2(C_MAX + 1);

  logic [1:0]    rs_q;
  logic          rst_core_n;
  logic          tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;
  logic          pre_en, pre_bit, tx_pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  rls_ctrl #(
    .TW(TW), .CHAN_W(CHAN_W), .MAX_RETRY(MAX_RETRY),
    .LV_PWR(TW'(C_PWR - 1)), .LV_FIRST(TW'(C_FIRST - 1)),
    .LV_RETUNE(TW'(C_RETUNE - 1)), .LV_SWITCH(TW'(C_SWITCH - 1)),
    .LV_PRE(TW'(C_PRE - 1))
  ) ctrl_i (
    .clk(clk), .rst_n(rst_core_n),
    .req_chan(chan_req_i), .chan_i(chan_sel_i),
    .req_tx(tx_req_i), .req_rx(rx_req_i),
    .ld_done(ld_done_i), .lock(lock_i),
    .tmr_done(tmr_done), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .pwr_en(pwr_en_o), .rx_sel_n(rx_sel_n_o), .tx_sel_n(tx_sel_n_o),
    .ld_req(ld_req_o), .ld_chan(ld_chan_o),
    .data_ready(data_ready_o), .lock_err(lock_err_o),
    .pre_en(pre_en), .tx_pass(tx_pass)
  );

  rls_timer #(.TW(TW)) timer_i (
    .clk(clk), .rst_n(rst_core_n),
    .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  rls_preamble #(.BIT_DIV(BIT_DIV), .PATTERN(PATTERN)) pre_i (
    .clk(clk), .rst_n(rst_core_n), .en(pre_en), .bit_o(pre_bit)
  );

  assign di_o = pre_en ? pre_bit : (tx_pass & tx_data_i);
endmodule

// File: rtl/radio_link_sequencer_chk.sv
module radio_link_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_en_o,
  input logic rx_sel_n_o,
  input logic tx_sel_n_o,
  input logic ld_req_o,
  input logic data_ready_o,
  input logic lock_err_o
);
  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en_o |-> (rx_sel_n_o && tx_sel_n_o));

  p_sel_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sel_n_o || tx_sel_n_o));

  p_gap_to_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_sel_n_o) |-> $past(rx_sel_n_o));

  p_gap_to_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_sel_n_o) |-> $past(tx_sel_n_o));

  p_load_in_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req_o |-> (!rx_sel_n_o && tx_sel_n_o));

  p_err_not_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_err_o) |-> !data_ready_o);

  p_ready_one_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready_o |-> (rx_sel_n_o != tx_sel_n_o));
endmodule

bind radio_link_sequencer radio_link_sequencer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pwr_en_o(pwr_en_o),
  .rx_sel_n_o(rx_sel_n_o), .tx_sel_n_o(tx_sel_n_o),
  .ld_req_o(ld_req_o), .data_ready_o(data_ready_o),
  .lock_err_o(lock_err_o)
);

// File: tb/radio_link_sequencer_tb_top.sv
`timescale 1ns/1ps
module radio_link_sequencer_tb_top;
  localparam int CLK_P  = 10;
  localparam int CW     = 5;
  localparam int BD     = 2;
  localparam int PWR_C  = 5;
  localparam int FIR_C  = 40;
  localparam int RET_C  = 20;
  localparam int SW_C   = 5;
  localparam int PRE_C  = 15;
  localparam int RETRY  = 2;

  logic clk, rst_n;
  logic chan_req, tx_req, rx_req, ld_done, lock, tx_data;
  logic [CW-1:0] chan_sel;
  logic pwr_en, rx_sel_n, tx_sel_n, ld_req, ready, lock_err, di;
  logic [CW-1:0] ld_chan;

  radio_link_sequencer #(
    .CLK_HZ(1000), .PWRUP_MS(PWR_C), .FIRST_MS(FIR_C), .RETUNE_MS(RET_C),
    .SWITCH_MS(SW_C), .PREAMBLE_MS(PRE_C), .MAX_RETRY(RETRY),
    .CHAN_W(CW), .BIT_DIV(BD), .PATTERN(0)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .chan_req_i(chan_req), .chan_sel_i(chan_sel),
    .tx_req_i(tx_req), .rx_req_i(rx_req), .ld_done_i(ld_done),
    .lock_i(lock), .tx_data_i(tx_data), .pwr_en_o(pwr_en),
    .rx_sel_n_o(rx_sel_n), .tx_sel_n_o(tx_sel_n), .ld_req_o(ld_req),
    .ld_chan_o(ld_chan), .data_ready_o(ready), .lock_err_o(lock_err),
    .di_o(di)
  );

  int total = 0;
  int bad = 0;
  bit done_flag = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    clk = 0;
    forever #(CLK_P/2) clk = ~clk;
  end

  // payload source changes just after rising edges
  int tx_ctr = 0;
  always @(posedge clk) begin
    tx_ctr <= tx_ctr + 1;
    tx_data <= tx_ctr[0] ^ tx_ctr[2];
  end

  // loader: answers a held request after three cycles
  int ld_wait = 0;
  always @(negedge clk) begin
    if (ld_done) begin
      ld_done <= 1'b0;
      ld_wait <= 0;
    end else if (ld_req) begin
      if (ld_wait == 2) ld_done <= 1'b1;
      ld_wait <= ld_wait + 1;
    end else ld_wait <= 0;
  end

  // behavioural reference: 0 off,1 pwr,2 wait-chan,3 load,4 settle,5 rx,
  // 6 rx-switch,7 gap,8 tx-switch,9 preamble,10 tx
  int m_st, m_rs, m_rem, m_dest, m_try, m_k, m_chan;
  bit m_first, m_err;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_rs = 0; m_rem = 0; m_dest = 0; m_try = 0;
      m_k = 0; m_chan = 0; m_first = 1; m_err = 0;
    end else if (m_rs < 2) begin
      m_rs++;
    end else begin
      case (m_st)
        0: begin m_st = 1; m_rem = PWR_C; end
        1: begin m_rem--; if (m_rem == 0) m_st = 2; end
        2: if (chan_req) begin m_chan = chan_sel; m_try = 0; m_st = 3; end
        3: if (ld_done) begin m_st = 4; m_rem = m_first ? FIR_C : RET_C; end
        4: begin
          m_rem--;
          if (m_rem == 0) begin
            if (lock) begin m_st = 5; m_first = 0; m_err = 0; m_try = 0; end
            else begin
              m_err = 1;
              if (m_try < RETRY) begin m_try++; m_st = 3; end
              else begin m_try = 0; m_st = 2; end
            end
          end
        end
        5, 6: begin
          if (chan_req) begin m_chan = chan_sel; m_try = 0; m_st = 3; end
          else if (tx_req) begin m_dest = 1; m_st = 7; end
          else if (m_st == 6) begin m_rem--; if (m_rem == 0) m_st = 5; end
        end
        8, 9, 10: begin
          if (chan_req) begin m_chan = chan_sel; m_try = 0; m_dest = 2; m_st = 7; end
          else if (rx_req) begin m_dest = 0; m_st = 7; end
          else if (m_st == 8) begin
            m_rem--;
            if (m_rem == 0) begin m_st = 9; m_rem = PRE_C; m_k = 0; end
          end else if (m_st == 9) begin
            m_rem--; m_k++;
            if (m_rem == 0) m_st = 10;
          end
        end
        7: begin
          if (m_dest == 1) begin m_st = 8; m_rem = SW_C; end
          else if (m_dest == 0) begin m_st = 6; m_rem = SW_C; end
          else m_st = 3;
        end
        default: m_st = 0;
      endcase
    end
  end

  function automatic bit pat_bit(input int k);
    return ((k / BD) % 2) == 0;
  endfunction

  // cycle bookkeeping for delay measurements
  int t_cyc = 0, t_ldd = 0, t_rdy = 0, t_rxf = 0, t_txf = 0, n_ld = 0;
  bit p_rdy = 0, p_rx = 1, p_tx = 1, p_ld = 0, cmp_on = 0;
  always @(posedge clk) begin
    t_cyc++;
    if (ld_done) t_ldd = t_cyc;
    cmp_on = 1;
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      bit e_rx, e_tx, e_di;
      e_rx = !(m_st inside {2, 3, 4, 5, 6});
      e_tx = !(m_st inside {8, 9, 10});
      e_di = (m_st == 9) ? pat_bit(m_k) : ((m_st == 10) ? tx_data : 1'b0);
      check(pwr_en == (m_st != 0), "R1 pwr_en", pwr_en, m_st != 0);
      check(rx_sel_n == e_rx, "R10 rx_sel_n", rx_sel_n, e_rx);
      check(tx_sel_n == e_tx, "R10 tx_sel_n", tx_sel_n, e_tx);
      check(ready == (m_st == 5 || m_st == 10), "R5 data_ready", ready, m_st == 5 || m_st == 10);
      check(ld_req == (m_st == 3), "R4 ld_req", ld_req, m_st == 3);
      check(ld_chan == CW'(m_chan), "R11 ld_chan", ld_chan, m_chan);
      check(lock_err == m_err, "R6 lock_err", lock_err, m_err);
      check(di == e_di, "R9 di", di, e_di);
    end
    if (ready && !p_rdy) t_rdy = t_cyc;
    if (!rx_sel_n && p_rx) t_rxf = t_cyc;
    if (!tx_sel_n && p_tx) t_txf = t_cyc;
    if (ld_req && !p_ld) n_ld++;
    p_rdy = ready; p_rx = rx_sel_n; p_tx = tx_sel_n; p_ld = ld_req;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic pulse(input bit c, input bit t, input bit r, input int ch);
    chan_sel = CW'(ch); chan_req = c; tx_req = t; rx_req = r;
    step();
    chan_req = 0; tx_req = 0; rx_req = 0;
  endtask

  task automatic wait_rise_ready();
    int c0 = t_rdy;
    while (t_rdy == c0) step();
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 0; chan_req = 0; tx_req = 0; rx_req = 0; chan_sel = '0;
    lock = 0; ld_done = 0;
    repeat (4) step();
    // R1: reset state
    check(!pwr_en && rx_sel_n && tx_sel_n && !ready, "R1 reset outputs",
          {pwr_en, rx_sel_n, tx_sel_n, ready}, 4'b0110);
    rst_n = 1;
    repeat (4) step();
    pulse(0, 1, 0, 0);                     // transmit during power-up: ignored
    step();
    check(tx_sel_n == 1, "R11 tx ignored in power-up", tx_sel_n, 1);
    while (rx_sel_n) step();
    check(pwr_en == 1, "R1 supply on before receive", pwr_en, 1);

    // first lock, lock-detect chattering early (R2, R5)
    pulse(1, 0, 0, 7);
    repeat (10) begin lock = ~lock; step(); end
    lock = 1;
    wait_rise_ready();
    check(t_rdy - t_ldd == FIR_C, "R2 first settle", t_rdy - t_ldd, FIR_C);
    check(ld_chan == 7, "R11 channel word", ld_chan, 7);
    check(!lock_err, "R5 early chatter ignored", lock_err, 0);

    // transmit switch with preamble (R8, R9)
    pulse(0, 1, 0, 0);
    while (tx_sel_n) step();
    repeat (SW_C) step();
    for (int b = 0; b < 4; b++) begin
      check(di == ((b % 2) == 0), "R9 preamble bit", di, (b % 2) == 0);
      repeat (BD) step();
    end
    wait_rise_ready();
    check(t_rdy - t_txf == SW_C + PRE_C, "R8 tx ready delay", t_rdy - t_txf, SW_C + PRE_C);
    repeat (3) step();
    check(di == tx_data, "R9 payload passes", di, tx_data);

    // retune from transmit (R4, R3), busy request ignored (R11)
    pulse(1, 0, 0, 9);
    while (!ld_req) step();
    check(!rx_sel_n && tx_sel_n, "R4 load in receive", {rx_sel_n, tx_sel_n}, 2'b01);
    while (!ld_done) step();
    repeat (3) step();
    pulse(1, 0, 0, 20);
    wait_rise_ready();
    check(t_rdy - t_ldd == RET_C, "R3 later settle", t_rdy - t_ldd, RET_C);
    check(ld_chan == 9, "R11 busy request dropped", ld_chan, 9);

    // receive request while receiving is ignored; rx switch cut into preamble (R7)
    pulse(0, 0, 1, 0);
    repeat (2) step();
    check(ready && !rx_sel_n, "R11 rx in rx ignored", {ready, rx_sel_n}, 2'b10);
    pulse(0, 1, 0, 0);
    while (tx_sel_n) step();
    repeat (8) step();
    pulse(0, 0, 1, 0);
    wait_rise_ready();
    check(t_rdy - t_rxf == SW_C, "R7 rx ready delay", t_rdy - t_rxf, SW_C);

    // lock high most of the window, low at its end: fails, retries (R5, R6)
    n_ld = 0;
    lock = 1;
    pulse(1, 0, 0, 3);
    while (!ld_done) step();
    repeat (15) step();
    lock = 0;
    while (n_ld < RETRY + 1) step();
    while (ld_req) step();
    repeat (RET_C + 5) step();
    check(lock_err == 1, "R5 late low fails check", lock_err, 1);
    check(!ready && !rx_sel_n, "R6 parked not ready", {ready, rx_sel_n}, 2'b00);
    check(n_ld == RETRY + 1, "R6 loader attempts", n_ld, RETRY + 1);
    pulse(0, 1, 0, 0);
    repeat (2) step();
    check(tx_sel_n == 1, "R11 tx ignored while waiting", tx_sel_n, 1);
    lock = 1;
    pulse(1, 0, 0, 12);
    wait_rise_ready();
    check(lock_err == 0, "R6 flag cleared on lock", lock_err, 0);

    // simultaneous channel and transmit request (R11)
    pulse(1, 1, 0, 4);
    step();
    check(ld_req && tx_sel_n, "R11 channel wins", {ld_req, tx_sel_n}, 2'b11);
    wait_rise_ready();
    check(ld_chan == 4, "R11 winning channel", ld_chan, 4);
    repeat (3) step();
    finish_run();
  end
endmodule